// File: doc/BRIEF.md
# Adaptive SIMD Configuration Search Engine

This block picks a lane-width and thread-depth pair for a SIMD core while a data-parallel kernel runs. The core runs one sampling interval with the suggested pair, measures the average cycles spent per task, and reports that figure with a one-cycle valid pulse. On the clock edge that takes the report, the engine records the result and puts out the next pair to try. Once further steps stop improving the result, it reports the best pair it has seen and raises a converged flag. It keeps that pair until the next kernel launch sends a restart pulse.

The search changes one axis at a time and always starts with depth. On each axis it tries one step up and one step down around the best point so far. It then keeps stepping in the direction that did better for as long as the cycles-per-task figure keeps falling. When a step stops helping, the step size is halved and the axis is searched again. When a step of one stops helping, the engine moves on to the other axis. Depth and width passes take turns until a full round leaves the best point unchanged. Width never goes above the lane count and depth never goes above the warp-slot count, so their product never goes above the hardware thread contexts. All stored configuration values are 8 bits wide.

Top module: `adapt_search_fsm`

## Requirements
- R1: Reset, and a restart pulse, set the output to width = LANES, depth = 1, converged = 0. They clear all search state and put the step sizes back to their start values. A restart in the same cycle as a measurement overrides the measurement.
- R2: Outputs change only on the clock edge that samples meas_valid = 1 or restart = 1. When neither is present, width, depth and converged hold their values.
- R3: cfg_width always stays in 1..LANES and cfg_depth always stays in 1..WARPS.
- R4: The first measurement after a restart is the baseline for the starting point. The next output is the upward depth probe: depth = best depth + depth step, clamped to WARPS.
- R5: The up probe and the down probe each take one interval. A probe counts as better only if its figure is strictly lower than the best figure. If both probes are better, the lower one wins, and the up probe wins a tie. If neither is better, the current step is finished.
- R6: A probe whose clamped value equals the best value on that axis is still output for one interval. Its measurement is ignored and the probe counts as not better.
- R7: After a direction is picked, the engine steps that way once per interval while each result is strictly better. The first result that is not better, or a step that cannot move, ends the current step.
- R8: The step sizes start at max(1, WARPS/2) for depth and max(1, LANES/2) for width. When a step ends with a size above one, the size is halved and the engine probes up again from the best point.
- R9: When a step of size one ends, a depth pass hands over to a width pass. A width pass starts a new round beginning with depth if the best point moved during the round; otherwise the search is done. Step sizes are not reset between rounds.
- R10: When the search is done, the output is the best point and converged = 1. Later measurements are ignored until a restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Kernel-launch pulse that starts a new search |
| meas_valid | input | 1 | One-cycle pulse: meas_cycles holds the figure for the last interval |
| meas_cycles | input | MEAS_W | Cycles per task measured with the current output pair |
| cfg_width | output | 8 | Suggested SIMD width for the next interval |
| cfg_depth | output | 8 | Suggested thread depth for the next interval |
| converged | output | 1 | Search finished; outputs hold the best pair |

## Verification
The stimulus sets up the cases a careless search gets wrong. Probes that clamp onto the best value are given very low figures: an engine that believed them would move to a point that is no better. Ties between a probe and the best figure are included, and an engine that treated equal as better would keep moving and never settle. A case where both probes beat the best by the same amount checks that the up direction wins. A round in which only depth moves is followed by a round in which nothing moves; an engine that ended after one round, or that reset its step sizes, would output a different sequence of pairs. Restarts after convergence, during a search and in the same cycle as a measurement check that the engine returns to its starting point.

// File: rtl/simd_search_pkg.sv
package simd_search_pkg;

    localparam int CFG_W = 8;

    typedef logic [CFG_W-1:0] cfg_val_t;

    typedef struct packed {
        cfg_val_t width;
        cfg_val_t depth;
    } simd_cfg_t;

    typedef enum logic [2:0] {
        ST_BASE   = 3'd0,
        ST_UP     = 3'd1,
        ST_DN     = 3'd2,
        ST_FOLLOW = 3'd3,
        ST_DONE   = 3'd4
    } srch_state_t;

    typedef enum logic {
        AX_DEPTH = 1'b0,
        AX_WIDTH = 1'b1
    } axis_t;

    // One step from base, kept inside [1, limit].
    function automatic cfg_val_t step_clamp(cfg_val_t base, cfg_val_t stride,
                                            logic down, cfg_val_t limit);
        logic [CFG_W:0] sum;
        if (down) begin
            return (base > stride) ? cfg_val_t'(base - stride) : cfg_val_t'(1);
        end
        sum = {1'b0, base} + {1'b0, stride};
        return (sum > {1'b0, limit}) ? limit : sum[CFG_W-1:0];
    endfunction

    function automatic cfg_val_t cfg_axis(simd_cfg_t c, axis_t a);
        return (a == AX_WIDTH) ? c.width : c.depth;
    endfunction

    function automatic simd_cfg_t cfg_set(simd_cfg_t c, axis_t a, cfg_val_t v);
        simd_cfg_t r;
        r = c;
        if (a == AX_WIDTH) r.width = v;
        else               r.depth = v;
        return r;
    endfunction

endpackage

// File: rtl/sa_stride_reg.sv
module sa_stride_reg
    import simd_search_pkg::*;
#(
    parameter cfg_val_t INIT = cfg_val_t'(1)
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  logic     halve,
    output cfg_val_t stride_q,
    output cfg_val_t stride_nxt
);

    always_comb begin
        stride_nxt = halve ? (stride_q >> 1) : stride_q;
    end

    always_ff @(posedge clk) begin
        if (rst || load) stride_q <= INIT;
        else             stride_q <= stride_nxt;
    end

endmodule

// File: rtl/sa_probe_calc.sv
module sa_probe_calc
    import simd_search_pkg::*;
#(
    parameter int LANES = 16,
    parameter int WARPS = 8
) (
    input  simd_cfg_t base,
    input  axis_t     axis,
    input  cfg_val_t  stride,
    input  logic      down,
    output simd_cfg_t cand,
    output logic      cand_moves
);

    localparam cfg_val_t LIM_W = cfg_val_t'(LANES);
    localparam cfg_val_t LIM_D = cfg_val_t'(WARPS);

    cfg_val_t lim;
    cfg_val_t from_v;
    cfg_val_t to_v;

    always_comb begin
        lim        = (axis == AX_WIDTH) ? LIM_W : LIM_D;
        from_v     = cfg_axis(base, axis);
        to_v       = step_clamp(from_v, stride, down, lim);
        cand       = cfg_set(base, axis, to_v);
        cand_moves = (to_v != from_v);
    end

endmodule

// File: rtl/sa_search_ctrl.sv
module sa_search_ctrl
    import simd_search_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int MEAS_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              meas_valid,
    input  logic [MEAS_W-1:0] meas_cycles,
    input  cfg_val_t          stride_d,
    input  cfg_val_t          stride_w,
    input  simd_cfg_t         cand,
    input  logic              cand_moves,
    output simd_cfg_t         n_best,
    output axis_t             n_axis,
    output logic              n_down,
    output logic [1:0]        halve,
    output simd_cfg_t         cfg_q,
    output logic              conv_q
);

    localparam simd_cfg_t START_CFG = '{width: cfg_val_t'(LANES), depth: cfg_val_t'(1)};

    srch_state_t       state_q, n_state;
    axis_t             axis_q;
    logic              dir_q;
    simd_cfg_t         best_q;
    logic [MEAS_W-1:0] best_m_q, n_best_m;
    simd_cfg_t         up_cfg_q;
    logic [MEAS_W-1:0] up_m_q, n_up_m;
    logic              up_ok_q, n_up_ok;
    logic              moves_q;
    logic              round_q, n_round;
    logic              probe;
    logic              finish;

    logic              better;
    logic              dn_ok;
    logic              up_win;
    logic              step_over;
    cfg_val_t          axis_stride;

    always_comb begin
        n_state   = state_q;
        n_best    = best_q;
        n_best_m  = best_m_q;
        n_axis    = axis_q;
        n_down    = dir_q;
        n_round   = round_q;
        n_up_m    = up_m_q;
        n_up_ok   = up_ok_q;
        halve     = 2'b00;
        probe     = 1'b0;
        finish    = 1'b0;
        step_over = 1'b0;
        better      = meas_cycles < best_m_q;
        dn_ok       = moves_q && better;
        up_win      = up_ok_q && (!dn_ok || (up_m_q <= meas_cycles));
        axis_stride = (axis_q == AX_WIDTH) ? stride_w : stride_d;

        if (meas_valid) begin
            unique case (state_q)
                ST_BASE: begin
                    n_best   = cfg_q;
                    n_best_m = meas_cycles;
                    n_down   = 1'b0;
                    n_state  = ST_UP;
                    probe    = 1'b1;
                end
                ST_UP: begin
                    n_up_m  = meas_cycles;
                    n_up_ok = moves_q && better;
                    n_down  = 1'b1;
                    n_state = ST_DN;
                    probe   = 1'b1;
                end
                ST_DN: begin
                    if (up_win) begin
                        n_best   = up_cfg_q;
                        n_best_m = up_m_q;
                        n_down   = 1'b0;
                        n_round  = 1'b1;
                        n_state  = ST_FOLLOW;
                        probe    = 1'b1;
                    end else if (dn_ok) begin
                        n_best   = cfg_q;
                        n_best_m = meas_cycles;
                        n_down   = 1'b1;
                        n_round  = 1'b1;
                        n_state  = ST_FOLLOW;
                        probe    = 1'b1;
                    end else begin
                        step_over = 1'b1;
                    end
                end
                ST_FOLLOW: begin
                    if (moves_q && better) begin
                        n_best   = cfg_q;
                        n_best_m = meas_cycles;
                        n_round  = 1'b1;
                        probe    = 1'b1;
                    end else begin
                        step_over = 1'b1;
                    end
                end
                default: begin
                end
            endcase

            if (step_over) begin
                n_down  = 1'b0;
                n_state = ST_UP;
                probe   = 1'b1;
                if (axis_stride > cfg_val_t'(1)) begin
                    halve[axis_q] = 1'b1;
                end else if (axis_q == AX_DEPTH) begin
                    n_axis = AX_WIDTH;
                end else if (n_round) begin
                    n_axis  = AX_DEPTH;
                    n_round = 1'b0;
                end else begin
                    n_state = ST_DONE;
                    probe   = 1'b0;
                    finish  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            state_q  <= ST_BASE;
            axis_q   <= AX_DEPTH;
            dir_q    <= 1'b0;
            best_q   <= START_CFG;
            best_m_q <= '1;
            up_cfg_q <= START_CFG;
            up_m_q   <= '1;
            up_ok_q  <= 1'b0;
            moves_q  <= 1'b0;
            round_q  <= 1'b0;
            cfg_q    <= START_CFG;
            conv_q   <= 1'b0;
        end else begin
            state_q  <= n_state;
            axis_q   <= n_axis;
            dir_q    <= n_down;
            best_q   <= n_best;
            best_m_q <= n_best_m;
            up_m_q   <= n_up_m;
            up_ok_q  <= n_up_ok;
            round_q  <= n_round;
            if (probe) begin
                cfg_q   <= cand;
                moves_q <= cand_moves;
                if (n_state == ST_UP) up_cfg_q <= cand;
            end
            if (finish) begin
                cfg_q  <= n_best;
                conv_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/adapt_search_fsm.sv
module adapt_search_fsm
    import simd_search_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int WARPS  = 8,
    parameter int MEAS_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              meas_valid,
    input  logic [MEAS_W-1:0] meas_cycles,
    output logic [7:0]        cfg_width,
    output logic [7:0]        cfg_depth,
    output logic              converged
);

    localparam cfg_val_t D_INIT = (WARPS / 2 >= 1) ? cfg_val_t'(WARPS / 2) : cfg_val_t'(1);
    localparam cfg_val_t W_INIT = (LANES / 2 >= 1) ? cfg_val_t'(LANES / 2) : cfg_val_t'(1);

    cfg_val_t   str_q [2];
    cfg_val_t   str_n [2];
    logic [1:0] halve;
    simd_cfg_t  n_best;
    axis_t      n_axis;
    logic       n_down;
    simd_cfg_t  cand;
    logic       cand_moves;
    simd_cfg_t  cfg_q;
    logic       conv_q;
    cfg_val_t   probe_stride;

    for (genvar a = 0; a < 2; a++) begin : g_stride
        sa_stride_reg #(
            .INIT ((a == 0) ? D_INIT : W_INIT)
        ) u_stride (
            .clk        (clk),
            .rst        (rst),
            .load       (restart),
            .halve      (halve[a]),
            .stride_q   (str_q[a]),
            .stride_nxt (str_n[a])
        );
    end

    assign probe_stride = (n_axis == AX_WIDTH) ? str_n[1] : str_n[0];

    sa_probe_calc #(
        .LANES (LANES),
        .WARPS (WARPS)
    ) u_probe (
        .base       (n_best),
        .axis       (n_axis),
        .stride     (probe_stride),
        .down       (n_down),
        .cand       (cand),
        .cand_moves (cand_moves)
    );

    sa_search_ctrl #(
        .LANES  (LANES),
        .MEAS_W (MEAS_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .restart     (restart),
        .meas_valid  (meas_valid),
        .meas_cycles (meas_cycles),
        .stride_d    (str_q[0]),
        .stride_w    (str_q[1]),
        .cand        (cand),
        .cand_moves  (cand_moves),
        .n_best      (n_best),
        .n_axis      (n_axis),
        .n_down      (n_down),
        .halve       (halve),
        .cfg_q       (cfg_q),
        .conv_q      (conv_q)
    );

    assign cfg_width = cfg_q.width;
    assign cfg_depth = cfg_q.depth;
    assign converged = conv_q;

endmodule

// File: rtl/adapt_search_chk.sv
module adapt_search_chk #(
    parameter int LANES = 16,
    parameter int WARPS = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       restart,
    input logic       meas_valid,
    input logic [7:0] cfg_width,
    input logic [7:0] cfg_depth,
    input logic       converged
);

    // R1
    restart_home_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cfg_width == 8'(LANES)) && (cfg_depth == 8'd1) && !converged);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!meas_valid && !restart) |=> ($stable(cfg_width) && $stable(cfg_depth) && $stable(converged)));

    // R3
    range_ok_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_width >= 8'd1) && (cfg_width <= 8'(LANES)) &&
        (cfg_depth >= 8'd1) && (cfg_depth <= 8'(WARPS)));

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (converged && !restart) |=> (converged && $stable(cfg_width) && $stable(cfg_depth)));

    // R10
    done_on_meas_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(converged) |-> $past(meas_valid));

endmodule

bind adapt_search_fsm adapt_search_chk #(
    .LANES (LANES),
    .WARPS (WARPS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .restart    (restart),
    .meas_valid (meas_valid),
    .cfg_width  (cfg_width),
    .cfg_depth  (cfg_depth),
    .converged  (converged)
);

// File: tb/tb_adapt_search_fsm.sv
`timescale 1ns/1ps
module tb_adapt_search_fsm;

    localparam int LANES  = 4;
    localparam int WARPS  = 4;
    localparam int MEAS_W = 16;
    localparam int NV     = 23;

    // {measurement, expected width, expected depth, expected converged}
    localparam logic [32:0] VEC [NV] = '{
        {16'd100, 8'd4, 8'd3, 1'b0},
        {16'd80,  8'd4, 8'd1, 1'b0},
        {16'd50,  8'd4, 8'd4, 1'b0},
        {16'd90,  8'd4, 8'd4, 1'b0},
        {16'd80,  8'd4, 8'd2, 1'b0},
        {16'd70,  8'd4, 8'd1, 1'b0},
        {16'd75,  8'd4, 8'd2, 1'b0},
        {16'd10,  8'd2, 8'd2, 1'b0},
        {16'd60,  8'd1, 8'd2, 1'b0},
        {16'd55,  8'd1, 8'd2, 1'b0},
        {16'd40,  8'd2, 8'd2, 1'b0},
        {16'd56,  8'd1, 8'd2, 1'b0},
        {16'd30,  8'd1, 8'd3, 1'b0},
        {16'd50,  8'd1, 8'd1, 1'b0},
        {16'd50,  8'd1, 8'd4, 1'b0},
        {16'd50,  8'd2, 8'd3, 1'b0},
        {16'd60,  8'd1, 8'd3, 1'b0},
        {16'd60,  8'd1, 8'd4, 1'b0},
        {16'd51,  8'd1, 8'd2, 1'b0},
        {16'd52,  8'd2, 8'd3, 1'b0},
        {16'd50,  8'd1, 8'd3, 1'b0},
        {16'd0,   8'd1, 8'd3, 1'b1},
        {16'd5,   8'd1, 8'd3, 1'b1}
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              restart;
    logic              meas_valid;
    logic [MEAS_W-1:0] meas_cycles;
    logic [7:0]        cfg_width;
    logic [7:0]        cfg_depth;
    logic              converged;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    adapt_search_fsm #(
        .LANES  (LANES),
        .WARPS  (WARPS),
        .MEAS_W (MEAS_W)
    ) dut (
        .clk         (clk),
        .rst         (rst),
        .restart     (restart),
        .meas_valid  (meas_valid),
        .meas_cycles (meas_cycles),
        .cfg_width   (cfg_width),
        .cfg_depth   (cfg_depth),
        .converged   (converged)
    );

    function automatic string tag_of(int i);
        case (i)
            0:               return "R4";
            1, 4, 11, 13,
            14, 18, 20:      return "R5";
            2, 7, 9, 16:     return "R6";
            3, 10:           return "R8";
            5, 8:            return "R7";
            6, 12, 15, 17,
            19:              return "R9";
            default:         return "R10";
        endcase
    endfunction

    task automatic check_out(string req, logic [7:0] ew, logic [7:0] ed, logic ec);
        checks++;
        if (cfg_width !== ew || cfg_depth !== ed || converged !== ec) begin
            failures++;
            $display("FAIL %s: got w=%0d d=%0d conv=%0b, expected w=%0d d=%0d conv=%0b",
                     req, cfg_width, cfg_depth, converged, ew, ed, ec);
        end
    endtask

    task automatic send_meas(logic [MEAS_W-1:0] m, logic rs);
        meas_cycles = m;
        meas_valid  = 1'b1;
        restart     = rs;
        @(posedge clk);
        @(negedge clk);
        meas_valid  = 1'b0;
        restart     = 1'b0;
    endtask

    task automatic pulse_restart();
        restart = 1'b1;
        @(posedge clk);
        @(negedge clk);
        restart = 1'b0;
    endtask

    initial begin
        rst         = 1'b1;
        restart     = 1'b0;
        meas_valid  = 1'b0;
        meas_cycles = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check_out("R1", 8'd4, 8'd1, 1'b0);

        for (int i = 0; i < NV; i++) begin
            if (i == 5) begin
                repeat (4) @(negedge clk);
                // R2: no measurement, outputs hold
                check_out("R2", 8'd4, 8'd2, 1'b0);
            end
            send_meas(VEC[i][32:17], 1'b0);
            check_out(tag_of(i), VEC[i][16:9], VEC[i][8:1], VEC[i][0]);
            checks++;
            // R3: outputs in range
            if (cfg_width < 8'd1 || cfg_width > 8'(LANES) ||
                cfg_depth < 8'd1 || cfg_depth > 8'(WARPS)) begin
                failures++;
                $display("FAIL R3: got w=%0d d=%0d, expected within 1..%0d / 1..%0d",
                         cfg_width, cfg_depth, LANES, WARPS);
            end
        end

        // R10: converged output holds while idle
        repeat (3) @(negedge clk);
        check_out("R10", 8'd1, 8'd3, 1'b0 ? 1'b0 : 1'b1);

        // R1: restart after convergence
        pulse_restart();
        check_out("R1", 8'd4, 8'd1, 1'b0);
        // R4: new baseline, step sizes back at start value
        send_meas(16'd100, 1'b0);
        check_out("R4", 8'd4, 8'd3, 1'b0);
        // R1: restart wins over a measurement in the same cycle
        send_meas(16'd7, 1'b1);
        check_out("R1", 8'd4, 8'd1, 1'b0);
        // R4: baseline taken again after restart
        send_meas(16'd200, 1'b0);
        check_out("R4", 8'd4, 8'd3, 1'b0);
        // R1: restart mid-search
        send_meas(16'd150, 1'b0);
        pulse_restart();
        check_out("R1", 8'd4, 8'd1, 1'b0);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: got no completion, expected end of test");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule